// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block works out which of a set of agents must receive an interrupt message. One request carries an 8-bit destination value, a bit that picks physical or logical addressing, a 2-bit shorthand code, the index of the sending agent, and a flag for lowest-priority delivery. From these the block builds a delivery mask with one bit per agent. When the lowest-priority flag is set, it also gives a one-hot mask that names the single lowest-numbered agent in that delivery mask.

Each agent has a physical ID (an input bus), a present bit (an input), and an 8-bit logical ID and a 4-bit addressing model. The logical ID and model are held in registers inside the block and written through a small configuration port. The match logic is combinational. The results are registered, so they appear one clock after the request strobe. Delivering the vector, arbitrating priority between agents and decoding message addresses belong to the surrounding logic.

Top module: `irq_dest_resolver`

## Requirements
- R1: Shorthand code 1 selects only the agent whose index equals `req_sender`. The destination field and the addressing mode are ignored.
- R2: Shorthand code 2 selects every agent, the sender included. The destination field and the addressing mode are ignored.
- R3: Shorthand code 3 selects every agent except the sender.
- R4: With shorthand code 0 and physical addressing (`req_logical`=0), destination 0xFF selects every agent.
- R5: With shorthand code 0, physical addressing and any destination other than 0xFF, each agent whose physical ID equals the destination is selected.
- R6: With shorthand code 0 and logical addressing (`req_logical`=1), an agent whose model is 4'hF (flat) is selected when the bitwise AND of the destination and its logical ID is nonzero.
- R7: In logical addressing, an agent whose model is 4'h0 (cluster) is selected when destination bits [7:4] equal logical ID bits [7:4] and destination bits [3:0] share at least one set bit with logical ID bits [3:0].
- R8: In logical addressing, an agent whose model is neither 4'h0 nor 4'hF is never selected.
- R9: An agent whose `agent_present` bit is 0 is never selected, under any shorthand or mode.
- R10: When `req_lowpri`=1, `out_pick` has exactly one bit set: the lowest-numbered set bit of `out_mask`. `out_pick` is 0 when `out_mask` is 0, and always 0 when `req_lowpri`=0.
- R11: After reset every agent has model 4'hF and logical ID 0x00, so no logical request selects any agent. A cycle with `cfg_we`=1 sets agent `cfg_idx` to `cfg_log_id` and `cfg_model`, and a request in a later cycle uses the new values.
- R12: `out_valid` is high in exactly the cycle after each cycle with `req_valid`=1. `out_mask` and `out_pick` take that request's result in the same cycle and hold it until the next request. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for agent configuration |
| cfg_idx | input | IDX_W (3) | Agent index being written |
| cfg_log_id | input | ID_W (8) | New logical ID |
| cfg_model | input | 4 | New addressing model (4'hF flat, 4'h0 cluster) |
| agent_present | input | N_AGENTS (8) | Per-agent present bit |
| agent_phys_id | input | N_AGENTS*ID_W (64) | Physical IDs; agent i at bits [i*8+7:i*8] |
| req_valid | input | 1 | Request strobe |
| req_dest | input | ID_W (8) | Destination value |
| req_logical | input | 1 | 0 = physical, 1 = logical addressing |
| req_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| req_sender | input | IDX_W (3) | Index of the sending agent |
| req_lowpri | input | 1 | Lowest-priority delivery: produce a single pick |
| out_valid | output | 1 | Result strobe, one cycle after `req_valid` |
| out_mask | output | N_AGENTS (8) | Delivery mask |
| out_pick | output | N_AGENTS (8) | One-hot chosen agent for lowest-priority delivery |

## Verification
A corrupted logical-ID or model register does not show at the ports until a logical request is made. It then shows as a missing or extra bit in `out_mask` for that agent, one cycle after the request. Cluster-model and flat-model destinations are both needed to expose a wrong model value. A wrong match or pick term appears on the very next `out_valid` for any request that reaches the affected agent. A faulty valid or hold register shows at once as `out_valid` high in the wrong cycle, or as a mask that changes between requests.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
   typedef enum logic [1:0] {
      SH_FIELD  = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

   localparam int          MODEL_W       = 4;
   localparam logic [3:0]  MODEL_FLAT    = 4'hF;
   localparam logic [3:0]  MODEL_CLUSTER = 4'h0;
endpackage

// File: rtl/irq_agent_cfg.sv
module irq_agent_cfg
   import irq_dest_pkg::*;
#(
   parameter int N_AGENTS = 8,
   parameter int ID_W     = 8,
   localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [IDX_W-1:0]            cfg_idx,
   input  logic [ID_W-1:0]             cfg_log_id,
   input  logic [MODEL_W-1:0]          cfg_model,
   output logic [N_AGENTS*ID_W-1:0]    log_ids,
   output logic [N_AGENTS*MODEL_W-1:0] models
);
   for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
      logic hit;
      assign hit = cfg_we && (cfg_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            log_ids[g*ID_W +: ID_W]       <= '0;
            models[g*MODEL_W +: MODEL_W]  <= MODEL_FLAT;
         end else if (hit) begin
            log_ids[g*ID_W +: ID_W]       <= cfg_log_id;
            models[g*MODEL_W +: MODEL_W]  <= cfg_model;
         end
      end
   end

   // R11: configuration only moves on a write strobe
   a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(log_ids) && $stable(models)));
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
   import irq_dest_pkg::*;
#(
   parameter int N_AGENTS = 8,
   parameter int ID_W     = 8,
   localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1,
   localparam int HALF    = ID_W / 2
) (
   input  logic [ID_W-1:0]             dest,
   input  logic                        logical,
   input  logic [1:0]                  shorthand,
   input  logic [IDX_W-1:0]            sender,
   input  logic [N_AGENTS-1:0]         present,
   input  logic [N_AGENTS*ID_W-1:0]    phys_ids,
   input  logic [N_AGENTS*ID_W-1:0]    log_ids,
   input  logic [N_AGENTS*MODEL_W-1:0] models,
   output logic [N_AGENTS-1:0]         mask
);
   shorthand_e sh;
   logic       bcast;

   assign sh    = shorthand_e'(shorthand);
   assign bcast = &dest;

   for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
      logic [ID_W-1:0]    lid;
      logic [MODEL_W-1:0] mdl;
      logic phys_hit, flat_hit, clus_hit, log_hit, field_hit, is_self, hit;

      assign lid      = log_ids[g*ID_W +: ID_W];
      assign mdl      = models[g*MODEL_W +: MODEL_W];
      assign phys_hit = bcast || (phys_ids[g*ID_W +: ID_W] == dest);
      assign flat_hit = |(dest & lid);
      assign clus_hit = (dest[ID_W-1:HALF] == lid[ID_W-1:HALF]) &&
                        (|(dest[HALF-1:0] & lid[HALF-1:0]));
      assign is_self  = (sender == IDX_W'(g));

      always_comb begin
         unique case (mdl)
            MODEL_FLAT:    log_hit = flat_hit;
            MODEL_CLUSTER: log_hit = clus_hit;
            default:       log_hit = 1'b0;
         endcase
         field_hit = logical ? log_hit : phys_hit;
         unique case (sh)
            SH_FIELD:  hit = field_hit;
            SH_SELF:   hit = is_self;
            SH_ALL:    hit = 1'b1;
            SH_OTHERS: hit = !is_self;
            default:   hit = 1'b0;
         endcase
      end

      assign mask[g] = present[g] && hit;
   end
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
   parameter int N_AGENTS   = 8,
   parameter int PICK_STYLE = 0   // 0: carry isolate, 1: explicit scan chain
) (
   input  logic [N_AGENTS-1:0] mask,
   output logic [N_AGENTS-1:0] pick
);
   if (PICK_STYLE == 0) begin : g_isolate
      assign pick = mask & (~mask + N_AGENTS'(1));
   end else begin : g_scan
      logic [N_AGENTS:0] seen;
      assign seen[0] = 1'b0;
      for (genvar g = 0; g < N_AGENTS; g++) begin : g_bit
         assign pick[g]   = mask[g] && !seen[g];
         assign seen[g+1] = seen[g] || mask[g];
      end
   end

   // R10: at most one agent chosen, and only from the mask
   always_comb begin
      a_r10_pick_onehot: assert ($onehot0(pick) && ((pick & ~mask) == '0));
   end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
   import irq_dest_pkg::*;
#(
   parameter int N_AGENTS   = 8,
   parameter int ID_W       = 8,
   parameter int PICK_STYLE = 0,
   localparam int IDX_W     = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [IDX_W-1:0]            cfg_idx,
   input  logic [ID_W-1:0]             cfg_log_id,
   input  logic [MODEL_W-1:0]          cfg_model,
   input  logic [N_AGENTS-1:0]         agent_present,
   input  logic [N_AGENTS*ID_W-1:0]    agent_phys_id,
   input  logic                        req_valid,
   input  logic [ID_W-1:0]             req_dest,
   input  logic                        req_logical,
   input  logic [1:0]                  req_shorthand,
   input  logic [IDX_W-1:0]            req_sender,
   input  logic                        req_lowpri,
   output logic                        out_valid,
   output logic [N_AGENTS-1:0]         out_mask,
   output logic [N_AGENTS-1:0]         out_pick
);
   initial begin
      a_param_agents: assert (N_AGENTS >= 1 && N_AGENTS <= 256)
         else $error("N_AGENTS out of range");
      a_param_idw: assert (ID_W >= 2 && ID_W % 2 == 0)
         else $error("ID_W must be even and at least 2");
      a_param_style: assert (PICK_STYLE == 0 || PICK_STYLE == 1)
         else $error("PICK_STYLE must be 0 or 1");
   end

   logic [N_AGENTS*ID_W-1:0]    log_ids;
   logic [N_AGENTS*MODEL_W-1:0] models;
   logic [N_AGENTS-1:0]         mask_c, pick_c;

   irq_agent_cfg #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_log_id(cfg_log_id), .cfg_model(cfg_model),
      .log_ids(log_ids), .models(models));

   irq_dest_match #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_match (
      .dest(req_dest), .logical(req_logical), .shorthand(req_shorthand),
      .sender(req_sender), .present(agent_present), .phys_ids(agent_phys_id),
      .log_ids(log_ids), .models(models), .mask(mask_c));

   irq_low_pick #(.N_AGENTS(N_AGENTS), .PICK_STYLE(PICK_STYLE)) u_pick (
      .mask(mask_c), .pick(pick_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mask  <= '0;
         out_pick  <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_mask <= mask_c;
            out_pick <= req_lowpri ? pick_c : '0;
         end
      end
   end

   // R12: result strobe follows the request strobe by one cycle
   a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   a_r12_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && $stable(out_mask) && $stable(out_pick)));
   // R9: absent agents never appear
   a_r9_absent: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ((out_mask & ~$past(agent_present)) == '0));
   // R1: self shorthand selects at most one agent
   a_r1_self_single: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_shorthand == 2'd1) |=> ($countones(out_mask) <= 1));
   // R10: a pick exists exactly when the mask is non-empty
   a_r10_pick_present: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_lowpri) |=> ((out_pick != '0) == (out_mask != '0)));
   a_r10_pick_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (out_pick != '0) |-> (((out_pick & out_mask) != '0) &&
                            (((out_pick - 1'b1) & out_mask) == '0)));
   a_r10_no_pick: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_lowpri) |=> (out_pick == '0));
endmodule

// File: tb/irq_dest_resolver_tb.sv
module irq_dest_resolver_tb;
   localparam int N = 8;
   localparam int W = 8;
   localparam int XW = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic [XW-1:0]  cfg_idx = '0;
   logic [W-1:0]   cfg_log_id = '0;
   logic [3:0]     cfg_model = '0;
   logic [N-1:0]   agent_present = '1;
   logic [N*W-1:0] agent_phys_id = '0;
   logic           req_valid = 1'b0;
   logic [W-1:0]   req_dest = '0;
   logic           req_logical = 1'b0;
   logic [1:0]     req_shorthand = '0;
   logic [XW-1:0]  req_sender = '0;
   logic           req_lowpri = 1'b0;
   logic           out_valid;
   logic [N-1:0]   out_mask, out_pick;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [W-1:0] m_lid [N];
   logic [3:0]   m_mdl [N];

   always #2 clk = ~clk;

   irq_dest_resolver u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_log_id(cfg_log_id), .cfg_model(cfg_model),
      .agent_present(agent_present), .agent_phys_id(agent_phys_id),
      .req_valid(req_valid), .req_dest(req_dest), .req_logical(req_logical),
      .req_shorthand(req_shorthand), .req_sender(req_sender),
      .req_lowpri(req_lowpri), .out_valid(out_valid), .out_mask(out_mask),
      .out_pick(out_pick));

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_mask(input logic [W-1:0] d, input bit lg,
                                             input logic [1:0] sh, input int snd);
      logic [N-1:0] m;
      for (int i = 0; i < N; i++) begin
         bit h;
         case (sh)
            2'd1: h = (i == snd);
            2'd2: h = 1'b1;
            2'd3: h = (i != snd);
            default: begin
               if (!lg) h = (d == 8'hFF) || (agent_phys_id[i*W +: W] == d);
               else if (m_mdl[i] == 4'hF) h = (d & m_lid[i]) != 0;
               else if (m_mdl[i] == 4'h0)
                  h = (d[7:4] == m_lid[i][7:4]) && ((d[3:0] & m_lid[i][3:0]) != 0);
               else h = 1'b0;
            end
         endcase
         m[i] = h && agent_present[i];
      end
      return m;
   endfunction

   function automatic logic [N-1:0] exp_pick(input logic [N-1:0] m, input bit lp);
      if (!lp) return '0;
      for (int i = 0; i < N; i++) if (m[i]) return N'(1) << i;
      return '0;
   endfunction

   task automatic cfg_write(input int idx, input logic [W-1:0] l, input logic [3:0] md);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = XW'(idx); cfg_log_id = l; cfg_model = md;
      @(negedge clk);
      cfg_we = 1'b0;
      m_lid[idx] = l; m_mdl[idx] = md;
   endtask

   task automatic request(input logic [W-1:0] d, input bit lg, input logic [1:0] sh,
                          input int snd, input bit lp, input string req);
      logic [N-1:0] em;
      @(negedge clk);
      req_valid = 1'b1; req_dest = d; req_logical = lg;
      req_shorthand = sh; req_sender = XW'(snd); req_lowpri = lp;
      em = exp_mask(d, lg, sh, snd);
      @(negedge clk);
      req_valid = 1'b0;
      check(out_valid === 1'b1, {req, " valid"}, 32'(out_valid), 1);
      check(out_mask === em, {req, " mask"}, 32'(out_mask), 32'(em));
      check(out_pick === exp_pick(em, lp), {"R10 pick ", req}, 32'(out_pick),
            32'(exp_pick(em, lp)));
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7341));
      for (int i = 0; i < N; i++) begin
         m_lid[i] = '0; m_mdl[i] = 4'hF;
         agent_phys_id[i*W +: W] = W'(i + 8'h10);
      end
      repeat (3) @(negedge clk);
      check(out_valid === 0 && out_mask === 0 && out_pick === 0, "R12 reset",
            {out_valid, out_mask, out_pick}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset config -> logical never matches
      request(8'hFF, 1'b1, 2'd0, 0, 1'b1, "R11 reset logical");
      // R12: idle cycle keeps valid low and mask held
      @(negedge clk);
      check(out_valid === 1'b0, "R12 idle", 32'(out_valid), 0);
      // R1/R2/R3 shorthands
      request(8'h00, 1'b0, 2'd1, 5, 1'b0, "R1 self");
      request(8'h13, 1'b1, 2'd2, 2, 1'b1, "R2 all");
      request(8'hFF, 1'b0, 2'd3, 0, 1'b1, "R3 others");
      // R4/R5 physical
      request(8'hFF, 1'b0, 2'd0, 1, 1'b0, "R4 broadcast");
      request(8'h14, 1'b0, 2'd0, 1, 1'b1, "R5 phys");
      agent_phys_id[6*W +: W] = 8'h14;
      request(8'h14, 1'b0, 2'd0, 1, 1'b0, "R5 phys dup");
      request(8'h55, 1'b0, 2'd0, 1, 1'b1, "R5 phys none");
      // R6/R7/R8 logical
      cfg_write(2, 8'h05, 4'hF);
      cfg_write(3, 8'h22, 4'h0);
      cfg_write(4, 8'h21, 4'h0);
      cfg_write(5, 8'hFF, 4'h7);
      request(8'h04, 1'b1, 2'd0, 0, 1'b1, "R6 flat");
      request(8'h23, 1'b1, 2'd0, 0, 1'b1, "R7 cluster");
      request(8'h33, 1'b1, 2'd0, 0, 1'b0, "R7 cluster other group");
      request(8'hFF, 1'b1, 2'd0, 0, 1'b0, "R8 bad model");
      // R9 absent
      agent_present = 8'b1010_0101;
      request(8'hFF, 1'b0, 2'd2, 0, 1'b1, "R9 absent all");
      request(8'h00, 1'b0, 2'd1, 1, 1'b1, "R9 absent self");
      agent_present = '1;
      // random mix
      for (int it = 0; it < 400; it++) begin
         int sh_v;
         string tag;
         if ($urandom_range(0, 3) == 0)
            cfg_write($urandom_range(0, N-1), W'($urandom),
                      ($urandom_range(0, 2) == 0) ? 4'($urandom) :
                      (($urandom_range(0, 1) == 1) ? 4'hF : 4'h0));
         if ($urandom_range(0, 4) == 0) agent_present = N'($urandom);
         if ($urandom_range(0, 5) == 0)
            agent_phys_id[$urandom_range(0, N-1)*W +: W] = W'($urandom_range(16, 23));
         sh_v = ($urandom_range(0, 1) == 1) ? 0 : $urandom_range(1, 3);
         tag = (sh_v == 1) ? "R1 rnd" : (sh_v == 2) ? "R2 rnd" : (sh_v == 3) ? "R3 rnd" :
               "R6 R7 R5 rnd";
         request(($urandom_range(0, 7) == 0) ? 8'hFF : W'($urandom_range(0, 63)),
                 1'($urandom), 2'(sh_v), $urandom_range(0, N-1), 1'($urandom), tag);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule